// File: doc/BRIEF.md
# Write-only two-wire wiper register interface

This block is the serial front end of a dual 256-step resistor ladder. It listens on an oversampled two-wire bus (SCL and SDA) and accepts write transactions only. A bus master sends a start condition and then a 7-bit device address. The address's upper four bits are fixed at binary 0101, and its lower three bits come from strap pins. A mode bit follows the address. After a matching address the master sends a command byte, then a data byte. The data byte is loaded into whichever of the two 8-bit wiper registers the command byte selects.

The slave never puts data on SDA. Its only output on the bus is a pull-down request, raised while it acknowledges on the ninth clock of a byte. The block outputs both wiper registers and a one-cycle update strobe for each wiper. Software sees no status and can read nothing back. The system clock must run at least eight times faster than SCL.

Top module: `wiper_serial_if`

## Requirements
- R1: After reset, both wiper outputs are 0x80, the SDA pull-down request is low and both update strobes are low.
- R2: The slave responds to the address byte when its upper seven bits (the first seven sent, most significant first) equal binary 0101 followed by strap[2], strap[1] and strap[0]. It acknowledges that byte by asserting the pull-down during the ninth SCL high phase.
- R3: When the address does not match, the slave does not acknowledge. It also ignores every following byte, acknowledging none and changing no register, until the next start condition.
- R4: When the eighth bit of the address byte is 1 (no-operation), the slave acknowledges the address and every following byte, but no wiper changes and no strobe fires.
- R5: In the command byte, bit 0 set selects wiper A and bit 1 set selects wiper B. Both may be set. Bits 7 to 2 are ignored, and a command with bits 1 and 0 both clear loads nothing. The command byte is acknowledged in all cases.
- R6: The data byte is received most significant bit first. It is written into every selected wiper when the falling SCL edge of its ninth clock is detected. In the same cycle, the update strobe of each written wiper is high for exactly one clock.
- R7: A stop condition (SDA rising while SCL is high) or a repeated start returns the slave to idle from any state. A partly received command or data byte is discarded and leaves both wipers unchanged.
- R8: After a data byte is acknowledged, the next byte in the same transaction is taken as a new command byte, so command and data pairs can follow one another.
- R9: The pull-down request changes only while SCL is low. It is asserted only over acknowledge clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Asynchronous bus clock line sample |
| sda_in | input | 1 | Asynchronous bus data line sample |
| strap | input | 3 | Address strap pins, strap[2] is sent first |
| sda_pull | output | 1 | 1 requests the pad to pull SDA low |
| wiper_a | output | 8 | Wiper A position register |
| wiper_b | output | 8 | Wiper B position register |
| upd_a | output | 1 | One-cycle strobe when wiper A is written |
| upd_b | output | 1 | One-cycle strobe when wiper B is written |

## Verification
The assertions assume a well-behaved master. SDA changes while SCL is high only to form a start or a stop. SCL holds each level for several system clocks. The master releases SDA over every ninth clock, so no stop can arrive while the slave is pulling the line. The bench models the bus as an open-drain wire. It holds each SCL quarter phase for four system clocks and changes SDA only in the middle of the low phase. It breaks off transfers only with proper stop or repeated-start sequences.

// File: rtl/wsl_pkg.sv
package wsl_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned WIPER_W   = BYTE_W;
    localparam int unsigned STRAP_W   = 3;
    localparam int unsigned NUM_WIPER = 2;
    localparam int unsigned CNT_W     = $clog2(BYTE_W);
    localparam logic [6-STRAP_W:0]  DEV_HI    = 4'b0101;
    localparam logic [WIPER_W-1:0]  WIPER_MID = 8'h80;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_AACK, ST_CMD, ST_CACK, ST_DATA, ST_DACK, ST_SKIP
    } link_st_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic                 load;
        logic [NUM_WIPER-1:0] sel;
        logic [WIPER_W-1:0]   data;
    } wr_req_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [STRAP_W-1:0] s);
        return b[BYTE_W-1:1] == {DEV_HI, s};
    endfunction

endpackage

// File: rtl/wsl_sync.sv
module wsl_sync
    import wsl_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_p, sda_p;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_p  <= scl_ff[STAGES-1];
            sda_p  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end

    a_r7_start_stop_excl: assert property (@(posedge clk) disable iff (rst)
        !(ev.start && ev.stop));
endmodule

// File: rtl/wsl_link.sv
module wsl_link
    import wsl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_ev_t            ev,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_pull,
    output wr_req_t            req
);
    link_st_t             st;
    logic [CNT_W-1:0]     cnt;
    logic [BYTE_W-1:0]    sh;
    logic                 full;
    logic                 nop_q;
    logic [NUM_WIPER-1:0] cmd_q;
    logic [WIPER_W-1:0]   data_q;
    logic                 load_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            full   <= 1'b0;
            nop_q  <= 1'b0;
            cmd_q  <= '0;
            data_q <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (ev.start) begin
                st   <= ST_ADDR;
                cnt  <= '0;
                full <= 1'b0;
            end else if (ev.stop) begin
                st   <= ST_IDLE;
                cnt  <= '0;
                full <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_CMD, ST_DATA: begin
                        if (ev.scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], ev.sda};
                            cnt <= cnt + 1'b1;
                            if (cnt == CNT_W'(BYTE_W-1)) full <= 1'b1;
                        end else if (ev.scl_fall && full) begin
                            full <= 1'b0;
                            case (st)
                                ST_ADDR: begin
                                    if (addr_hit(sh, strap)) begin
                                        nop_q <= sh[0];
                                        st    <= ST_AACK;
                                    end else begin
                                        st    <= ST_SKIP;
                                    end
                                end
                                ST_CMD: begin
                                    cmd_q <= sh[NUM_WIPER-1:0];
                                    st    <= ST_CACK;
                                end
                                default: begin
                                    data_q <= sh;
                                    st     <= ST_DACK;
                                end
                            endcase
                        end
                    end
                    ST_AACK: if (ev.scl_fall) st <= ST_CMD;
                    ST_CACK: if (ev.scl_fall) st <= ST_DATA;
                    ST_DACK: if (ev.scl_fall) begin
                        st     <= ST_CMD;
                        load_q <= ~nop_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull = (st == ST_AACK) || (st == ST_CACK) || (st == ST_DACK);

    always_comb begin
        req.load = load_q;
        req.sel  = cmd_q;
        req.data = data_q;
    end

    a_r4_nop_no_load: assert property (@(posedge clk) disable iff (rst)
        req.load |-> !nop_q);
    a_r3_skip_silent: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP) |-> !sda_pull);
    a_r7_stop_idle: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_pull && !req.load));
    a_r9_pull_rise_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !ev.scl);
endmodule

// File: rtl/wsl_wipers.sv
module wsl_wipers
    import wsl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  wr_req_t                           req,
    output logic [NUM_WIPER-1:0][WIPER_W-1:0] wq,
    output logic [NUM_WIPER-1:0]              upd
);
    for (genvar i = 0; i < NUM_WIPER; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                wq[i]  <= WIPER_MID;
                upd[i] <= 1'b0;
            end else begin
                upd[i] <= req.load & req.sel[i];
                if (req.load && req.sel[i]) wq[i] <= req.data;
            end
        end

        a_r6_change_needs_strobe: assert property (@(posedge clk) disable iff (rst)
            !$stable(wq[i]) |-> upd[i]);
    end

    a_r5_no_sel_no_upd: assert property (@(posedge clk) disable iff (rst)
        (req.load && req.sel == '0) |=> (upd == '0));
endmodule

// File: rtl/wiper_serial_if.sv
module wiper_serial_if
    import wsl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    output logic               sda_pull,
    output logic [WIPER_W-1:0] wiper_a,
    output logic [WIPER_W-1:0] wiper_b,
    output logic               upd_a,
    output logic               upd_b
);
    bus_ev_t                           ev;
    wr_req_t                           req;
    logic [NUM_WIPER-1:0][WIPER_W-1:0] wq;
    logic [NUM_WIPER-1:0]              upd;

    wsl_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    wsl_link u_link (
        .clk(clk), .rst(rst), .ev(ev), .strap(strap),
        .sda_pull(sda_pull), .req(req)
    );

    wsl_wipers u_wipers (
        .clk(clk), .rst(rst), .req(req), .wq(wq), .upd(upd)
    );

    assign wiper_a = wq[0];
    assign wiper_b = wq[1];
    assign upd_a   = upd[0];
    assign upd_b   = upd[1];

    a_r9_pull_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && $past(ev.scl)) |-> $stable(sda_pull));
endmodule

// File: tb/wiper_serial_if_tb.sv
module wiper_serial_if_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_pull, upd_a, upd_b;
    logic [7:0] wiper_a, wiper_b;
    wire        sda_bus = sda_drv & ~sda_pull;

    int n_chk = 0, n_fail = 0;
    int cnt_a = 0, cnt_b = 0;
    logic [7:0] exp_a = 8'h80, exp_b = 8'h80;

    always #2.5 clk = ~clk;

    wiper_serial_if u_dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .strap(strap),
        .sda_pull(sda_pull), .wiper_a(wiper_a), .wiper_b(wiper_b),
        .upd_a(upd_a), .upd_b(upd_b)
    );

    always @(posedge clk) begin
        if (!rst && upd_a) cnt_a <= cnt_a + 1;
        if (!rst && upd_b) cnt_b <= cnt_b + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        wq(); sda_drv = 1'b1;
        wq(); scl = 1'b1;
        wq(); sda_drv = 1'b0;
        wq(); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wq(); sda_drv = 1'b0;
        wq(); scl = 1'b1;
        wq(); sda_drv = 1'b1;
        wq(); wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            wq(); sda_drv = b[i];
            wq(); scl = 1'b1;
            wq(); wq(); scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        wq(); sda_drv = 1'b1;
        wq(); scl = 1'b1;
        wq(); acked = !sda_bus;
        wq(); scl = 1'b0;
    endtask

    task automatic check_wipers(input string tag);
        chk(wiper_a == exp_a, tag, wiper_a, exp_a);
        chk(wiper_b == exp_b, tag, wiper_b, exp_b);
    endtask

    task automatic write_txn(input logic [6:0] adr, input bit nop, input logic [7:0] cmd,
                             input logic [7:0] dat, output bit k0, output bit k1, output bit k2);
        bus_start();
        send_byte({adr, nop}, k0);
        send_byte(cmd, k1);
        send_byte(dat, k2);
        bus_stop();
    endtask

    task automatic t_reset();
        chk(wiper_a == 8'h80, "R1 wiper_a", wiper_a, 8'h80);
        chk(wiper_b == 8'h80, "R1 wiper_b", wiper_b, 8'h80);
        chk(sda_pull == 1'b0, "R1 pull", sda_pull, 0);
        chk(!upd_a && !upd_b, "R1 strobes", {upd_a, upd_b}, 0);
    endtask

    task automatic t_write_a();
        bit k0, k1, k2;
        int ca = cnt_a, cb = cnt_b;
        write_txn(7'b0101101, 1'b0, 8'h01, 8'h3C, k0, k1, k2);
        exp_a = 8'h3C;
        chk(k0 && k1 && k2, "R2 acks", {k0, k1, k2}, 7);
        check_wipers("R6 write A msb-first");
        chk(cnt_a == ca + 1 && cnt_b == cb, "R6 strobe A once", cnt_a - ca, 1);
    endtask

    task automatic t_write_b();
        bit k0, k1, k2;
        int ca = cnt_a, cb = cnt_b;
        write_txn(7'b0101101, 1'b0, 8'h02, 8'h01, k0, k1, k2);
        exp_b = 8'h01;
        check_wipers("R5 select B");
        chk(cnt_b == cb + 1 && cnt_a == ca, "R6 strobe B once", cnt_b - cb, 1);
    endtask

    task automatic t_both_extra_bits();
        bit k0, k1, k2;
        int ca = cnt_a, cb = cnt_b;
        write_txn(7'b0101101, 1'b0, 8'hF3, 8'hA5, k0, k1, k2);
        exp_a = 8'hA5; exp_b = 8'hA5;
        check_wipers("R5 both with upper bits set");
        chk(cnt_a == ca + 1 && cnt_b == cb + 1, "R6 both strobes", cnt_a - ca, 1);
    endtask

    task automatic t_no_select();
        bit k0, k1, k2;
        int ca = cnt_a, cb = cnt_b;
        write_txn(7'b0101101, 1'b0, 8'hFC, 8'h55, k0, k1, k2);
        chk(k1 && k2, "R5 command acked", {k1, k2}, 3);
        check_wipers("R5 no wiper selected");
        chk(cnt_a == ca && cnt_b == cb, "R5 no strobe", cnt_a - ca, 0);
    endtask

    task automatic t_mismatch();
        bit k0, k1, k2;
        write_txn(7'b0101100, 1'b0, 8'h03, 8'h11, k0, k1, k2);
        chk(!k0 && !k1 && !k2, "R3 no ack low bits", {k0, k1, k2}, 0);
        check_wipers("R3 unchanged");
        write_txn(7'b0111101, 1'b0, 8'h03, 8'h22, k0, k1, k2);
        chk(!k0 && !k1 && !k2, "R3 no ack high bits", {k0, k1, k2}, 0);
        check_wipers("R3 unchanged high");
    endtask

    task automatic t_nop();
        bit k0, k1, k2;
        int ca = cnt_a, cb = cnt_b;
        write_txn(7'b0101101, 1'b1, 8'h03, 8'h77, k0, k1, k2);
        chk(k0 && k1 && k2, "R4 nop acks", {k0, k1, k2}, 7);
        check_wipers("R4 nop unchanged");
        chk(cnt_a == ca && cnt_b == cb, "R4 no strobe", cnt_a - ca, 0);
    endtask

    task automatic t_abort_stop();
        bit k;
        bus_start();
        send_byte(8'b0101101_0, k);
        send_byte(8'h03, k);
        send_bits(8'hFF, 5);
        bus_stop();
        check_wipers("R7 stop mid data");
        chk(sda_pull == 1'b0, "R7 idle pull", sda_pull, 0);
    endtask

    task automatic t_abort_restart();
        bit k0, k1, k2;
        bus_start();
        send_byte(8'b0101101_0, k0);
        send_bits(8'h03, 4);
        bus_start();
        send_byte(8'b0101101_0, k0);
        send_byte(8'h01, k1);
        send_byte(8'h96, k2);
        bus_stop();
        exp_a = 8'h96;
        chk(k0 && k1 && k2, "R7 restart acks", {k0, k1, k2}, 7);
        check_wipers("R7 restart then write");
    endtask

    task automatic t_pairs();
        bit k0, k1, k2, k3, k4;
        bus_start();
        send_byte(8'b0101101_0, k0);
        send_byte(8'h01, k1);
        send_byte(8'h12, k2);
        send_byte(8'h02, k3);
        send_byte(8'hED, k4);
        bus_stop();
        exp_a = 8'h12; exp_b = 8'hED;
        chk(k3 && k4, "R8 second pair acked", {k3, k4}, 3);
        check_wipers("R8 two pairs");
    endtask

    task automatic t_straps();
        bit k0, k1, k2;
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            write_txn({4'b0101, 3'(s)}, 1'b0, 8'h01, 8'(8'h40 + s), k0, k1, k2);
            exp_a = 8'(8'h40 + s);
            chk(k0, "R2 strap address ack", k0, 1);
            chk(wiper_a == exp_a, "R2 strap write", wiper_a, exp_a);
        end
        strap = 3'b101;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_up();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_write_a();
        t_write_b();
        t_both_extra_bits();
        t_no_select();
        t_mismatch();
        t_nop();
        t_abort_stop();
        t_abort_restart();
        t_pairs();
        t_straps();
        finish_up();
    end
endmodule